// File: doc/BRIEF.md
# Opcode and Mode Decoder

This block turns the two leading bytes of an instruction, an operation byte and an operand-mode byte, into the control fields a fetch/execute controller needs. From them it derives the operation class, the kind of the destination and source operands, whether an address or constant byte must follow, whether a register-select byte follows, the whole instruction length in bytes, and whether the operation updates the flags or writes its destination. Combinations that mean nothing are reported as illegal, with every control field forced to an inert value.

The controller offers a header with `in_valid` high. The decoded fields appear one clock later with `out_valid` high, and they hold while no new header is offered. Every operation carries the mode byte except the idle and stop operations, which are a single byte. The controller fetches the remaining bytes and executes the instruction. Register numbers travel in one extra byte: the destination index is in the upper nibble and the source index in the lower nibble.

Top module: `opmode_decoder`

## Requirements
- R1: After reset, and before any header is offered, out_valid is 0 and every output field is 0.
- R2: Every header offered with in_valid high gives out_valid high on the next clock with its decoded fields. A clock with in_valid low gives out_valid low, and all fields keep their previous values.
- R3: Operation byte 0x00 decodes to class 0 (idle) and 0xFF to class 14 (stop). Bytes 0x01 to 0x0D decode to the class equal to their value: 1 copy, 2 add, 3 subtract, 4 and, 5 or, 6 xor, 7 invert, 8 jump, 9 jump-if-zero, 10 jump-if-carry, 11 shift-left, 12 shift-right, 13 compare.
- R4: Operand kinds are encoded 0 none, 1 register, 2 memory, 3 constant. For the two-operand classes (1–6, 11–13), mode byte 0x00 gives dst=register and src=register. Mode 0x01 gives register and memory, 0x02 memory and register, 0x03 register and constant, 0x05 memory and memory, and 0x06 memory and constant. The destination is never a constant.
- R5: For a two-operand class, mode 0x04 or any mode above 0x06 is illegal.
- R6: Any operation byte from 0x0E to 0xFE is illegal, whatever the mode.
- R7: For the idle and stop classes the mode byte is ignored. Both operand kinds are none, the length is 1, and the header is never illegal.
- R8: Invert accepts only mode 0x00 (dst=register) and 0x01 (dst=memory), with src none. The three jumps accept only 0x00 (src=register), 0x01 (src=memory) and 0x03 (src=constant), with dst none. Every other mode is illegal for these classes.
- R9: A legal header with a mode byte has length 2. The length grows by 1 if any operand is a register, and by 1 for each memory or constant operand. The result always lies from 1 to 4.
- R10: need_ext is 1 exactly when a memory or constant operand is present. need_regbyte is 1 exactly when a register operand is present.
- R11: flags_we is 1 only for classes 2–7 and 11–13; copy, the jumps, idle and stop leave the flags alone. dst_we is 1 only for classes 1–7, 11 and 12; compare and the jumps write no destination.
- R12: An illegal header gives class 15, both kinds none, length 2, and need_ext, need_regbyte, flags_we and dst_we all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header offered this cycle |
| in_opcode | input | 8 | Operation byte |
| in_mode | input | 8 | Operand-mode byte |
| out_valid | output | 1 | Decoded fields are fresh |
| out_class | output | 4 | Operation class (R3 encoding, 15 = illegal) |
| out_dst_kind | output | 2 | Destination operand kind |
| out_src_kind | output | 2 | Source operand kind |
| out_need_ext | output | 1 | Address or constant byte(s) follow |
| out_need_regbyte | output | 1 | Register-select byte follows |
| out_length | output | 3 | Total instruction length in bytes |
| out_flags_we | output | 1 | Operation updates the flags |
| out_dst_we | output | 1 | Operation writes its destination |
| out_illegal | output | 1 | Header combination is undefined |

## Verification
The assertions take the header to be stable and fully known whenever in_valid is high. They also take in_valid to be low or high, never unknown, from the first clock after reset. The stimulus follows this by driving every input only on the falling clock edge, and it never leaves the operation or mode bytes undriven. Each decode runs through a full sweep of operation bytes and mode bytes, including mode 0x04 and modes far above 0x06, so every input value the decoder can meet is a defined byte.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

   typedef enum logic [3:0] {
      CL_IDLE = 4'd0,  CL_COPY = 4'd1,  CL_SUM  = 4'd2,  CL_DIFF = 4'd3,
      CL_AND  = 4'd4,  CL_OR   = 4'd5,  CL_XOR  = 4'd6,  CL_INV  = 4'd7,
      CL_BR   = 4'd8,  CL_BRZ  = 4'd9,  CL_BRC  = 4'd10, CL_SHL  = 4'd11,
      CL_SHR  = 4'd12, CL_COMP = 4'd13, CL_STOP = 4'd14, CL_BAD  = 4'd15
   } op_class_e;

   typedef enum logic [1:0] {
      K_NONE = 2'd0, K_REG = 2'd1, K_MEM = 2'd2, K_IMM = 2'd3
   } opnd_kind_e;

   // How many operands a class takes and which side they sit on
   typedef enum logic [1:0] {
      AR_NONE = 2'd0, AR_DST = 2'd1, AR_SRC = 2'd2, AR_PAIR = 2'd3
   } arity_e;

   typedef struct packed {
      op_class_e  cls;
      opnd_kind_e dk;
      opnd_kind_e sk;
      logic       ext;
      logic       rb;
      logic       fw;
      logic       dw;
      logic       ill;
   } dec_fields_t;

endpackage

// File: rtl/opmode_class_dec.sv
module opmode_class_dec
   import opmode_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   output op_class_e        cls,
   output arity_e           arity,
   output logic             known,
   output logic             flags_we,
   output logic             dst_we
);

   localparam logic [OPC_W-1:0] STOP_CODE = {OPC_W{1'b1}};
   localparam logic [OPC_W-1:0] LAST_DENSE = OPC_W'(13);

   logic is_branch;

   always_comb begin
      cls      = CL_BAD;
      arity    = AR_NONE;
      known    = 1'b0;
      flags_we = 1'b0;
      dst_we   = 1'b0;
      is_branch = 1'b0;
      if (opcode == '0) begin
         cls   = CL_IDLE;
         known = 1'b1;
      end else if (opcode == STOP_CODE) begin
         cls   = CL_STOP;
         known = 1'b1;
      end else if (opcode <= LAST_DENSE) begin
         cls       = op_class_e'(opcode[3:0]);
         known     = 1'b1;
         is_branch = (cls == CL_BR) || (cls == CL_BRZ) || (cls == CL_BRC);
         if (cls == CL_INV)  arity = AR_DST;
         else if (is_branch) arity = AR_SRC;
         else                arity = AR_PAIR;
         flags_we = !(is_branch || cls == CL_COPY);
         dst_we   = !(is_branch || cls == CL_COMP);
      end
   end

endmodule

// File: rtl/opmode_operand_dec.sv
module opmode_operand_dec
   import opmode_pkg::*;
#(
   parameter int MODE_W = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  arity_e            arity,
   output opnd_kind_e        dk,
   output opnd_kind_e        sk,
   output logic              legal
);

   logic       hi_zero;
   logic [2:0] sel;

   assign hi_zero = (mode >> 3) == '0;
   assign sel     = mode[2:0];

   always_comb begin
      dk    = K_NONE;
      sk    = K_NONE;
      legal = 1'b0;
      unique case (arity)
         AR_NONE: legal = 1'b1;
         AR_PAIR: if (hi_zero) begin
            legal = 1'b1;
            case (sel)
               3'd0:    begin dk = K_REG; sk = K_REG; end
               3'd1:    begin dk = K_REG; sk = K_MEM; end
               3'd2:    begin dk = K_MEM; sk = K_REG; end
               3'd3:    begin dk = K_REG; sk = K_IMM; end
               3'd5:    begin dk = K_MEM; sk = K_MEM; end
               3'd6:    begin dk = K_MEM; sk = K_IMM; end
               default: legal = 1'b0;
            endcase
         end
         AR_DST: if (hi_zero) begin
            legal = 1'b1;
            case (sel)
               3'd0:    dk = K_REG;
               3'd1:    dk = K_MEM;
               default: legal = 1'b0;
            endcase
         end
         AR_SRC: if (hi_zero) begin
            legal = 1'b1;
            case (sel)
               3'd0:    sk = K_REG;
               3'd1:    sk = K_MEM;
               3'd3:    sk = K_IMM;
               default: legal = 1'b0;
            endcase
         end
         default: legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/opmode_len_calc.sv
module opmode_len_calc
   import opmode_pkg::*;
#(
   parameter int ADDR_BYTES = 1,
   parameter int IMM_BYTES  = 1,
   parameter int LEN_W      = 3
) (
   input  arity_e           arity,
   input  opnd_kind_e       dk,
   input  opnd_kind_e       sk,
   output logic [LEN_W-1:0] length,
   output logic             need_ext,
   output logic             need_rb
);

   function automatic int kind_bytes(opnd_kind_e k);
      case (k)
         K_MEM:   return ADDR_BYTES;
         K_IMM:   return IMM_BYTES;
         default: return 0;
      endcase
   endfunction

   int ext_bytes;
   int total;

   always_comb begin
      ext_bytes = kind_bytes(dk) + kind_bytes(sk);
      need_rb   = (dk == K_REG) || (sk == K_REG);
      need_ext  = ext_bytes != 0;
      if (arity == AR_NONE) total = 1;
      else                  total = 2 + (need_rb ? 1 : 0) + ext_bytes;
      length = LEN_W'(total);
   end

endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
   import opmode_pkg::*;
#(
   parameter int  OPC_W      = 8,
   parameter int  MODE_W     = 8,
   parameter int  ADDR_BYTES = 1,
   parameter int  IMM_BYTES  = 1,
   parameter bit  OUT_REG    = 1'b1,
   localparam int MAX_EXT    = (ADDR_BYTES > IMM_BYTES) ? ADDR_BYTES : IMM_BYTES,
   localparam int MAX_LEN    = 3 + 2 * MAX_EXT,
   localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  in_opcode,
   input  logic [MODE_W-1:0] in_mode,
   output logic              out_valid,
   output logic [3:0]        out_class,
   output logic [1:0]        out_dst_kind,
   output logic [1:0]        out_src_kind,
   output logic              out_need_ext,
   output logic              out_need_regbyte,
   output logic [LEN_W-1:0]  out_length,
   output logic              out_flags_we,
   output logic              out_dst_we,
   output logic              out_illegal
);

   if (OPC_W < 4) begin : g_bad_opc_w
      $error("opmode_decoder: OPC_W must be at least 4");
   end
   if (MODE_W < 3) begin : g_bad_mode_w
      $error("opmode_decoder: MODE_W must be at least 3");
   end
   if (ADDR_BYTES < 1 || IMM_BYTES < 1) begin : g_bad_ext
      $error("opmode_decoder: operand byte counts must be at least 1");
   end

   op_class_e        cls;
   arity_e           arity;
   logic             known, fw, dw, legal, ext, rb;
   opnd_kind_e       dk, sk;
   logic [LEN_W-1:0] len;

   opmode_class_dec #(.OPC_W(OPC_W)) u_class (
      .opcode(in_opcode), .cls(cls), .arity(arity), .known(known),
      .flags_we(fw), .dst_we(dw)
   );

   opmode_operand_dec #(.MODE_W(MODE_W)) u_operand (
      .mode(in_mode), .arity(arity), .dk(dk), .sk(sk), .legal(legal)
   );

   opmode_len_calc #(.ADDR_BYTES(ADDR_BYTES), .IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)) u_len (
      .arity(arity), .dk(dk), .sk(sk), .length(len), .need_ext(ext), .need_rb(rb)
   );

   dec_fields_t      nxt, cur;
   logic [LEN_W-1:0] nxt_len, cur_len;
   logic             cur_valid;

   always_comb begin
      if (known && legal) begin
         nxt     = '{cls: cls, dk: dk, sk: sk, ext: ext, rb: rb, fw: fw, dw: dw, ill: 1'b0};
         nxt_len = len;
      end else begin
         nxt     = '{cls: CL_BAD, dk: K_NONE, sk: K_NONE, ext: 1'b0, rb: 1'b0,
                     fw: 1'b0, dw: 1'b0, ill: 1'b1};
         nxt_len = LEN_W'(2);
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur_valid <= 1'b0;
            cur       <= '{cls: CL_IDLE, dk: K_NONE, sk: K_NONE, ext: 1'b0, rb: 1'b0,
                           fw: 1'b0, dw: 1'b0, ill: 1'b0};
            cur_len   <= '0;
         end else begin
            cur_valid <= in_valid;
            if (in_valid) begin
               cur     <= nxt;
               cur_len <= nxt_len;
            end
         end
      end

      assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(out_class) && $stable(out_length)));
   end else begin : g_comb
      assign cur_valid = in_valid;
      assign cur       = nxt;
      assign cur_len   = nxt_len;
   end

   assign out_valid        = cur_valid;
   assign out_class        = cur.cls;
   assign out_dst_kind     = cur.dk;
   assign out_src_kind     = cur.sk;
   assign out_need_ext     = cur.ext;
   assign out_need_regbyte = cur.rb;
   assign out_length       = cur_len;
   assign out_flags_we     = cur.fw;
   assign out_dst_we       = cur.dw;
   assign out_illegal      = cur.ill;

   assert_len_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_length >= LEN_W'(1) && out_length <= LEN_W'(MAX_LEN)));
   assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_class == CL_BAD && !out_flags_we && !out_dst_we
                                      && out_dst_kind == K_NONE && out_src_kind == K_NONE));
   assert_no_imm_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_dst_kind != K_IMM));
   assert_nomode_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_class == CL_IDLE || out_class == CL_STOP))
         |-> (out_length == LEN_W'(1) && !out_illegal));
   assert_ext_has_operand_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_need_ext) |-> (out_dst_kind == K_MEM || out_src_kind == K_MEM
                                       || out_src_kind == K_IMM));

endmodule

// File: tb/opmode_decoder_tb.sv
`timescale 1ns/1ps
module opmode_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_opcode = 8'h00;
   logic [7:0] in_mode = 8'h00;
   logic       out_valid, out_need_ext, out_need_regbyte, out_flags_we, out_dst_we, out_illegal;
   logic [3:0] out_class;
   logic [1:0] out_dst_kind, out_src_kind;
   logic [2:0] out_length;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   opmode_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode), .in_mode(in_mode),
      .out_valid(out_valid), .out_class(out_class), .out_dst_kind(out_dst_kind),
      .out_src_kind(out_src_kind), .out_need_ext(out_need_ext),
      .out_need_regbyte(out_need_regbyte), .out_length(out_length),
      .out_flags_we(out_flags_we), .out_dst_we(out_dst_we), .out_illegal(out_illegal)
   );

   // {class, dst, src, ext, regbyte, length, flags_we, dst_we, illegal}
   function automatic logic [15:0] observed();
      return {out_class, out_dst_kind, out_src_kind, out_need_ext, out_need_regbyte,
              out_length, out_flags_we, out_dst_we, out_illegal};
   endfunction

   function automatic logic [15:0] expect_of(logic [7:0] op, logic [7:0] md);
      logic [3:0] c = 4'd15;
      logic [1:0] dk = 2'd0, sk = 2'd0;
      logic ok = 1'b0, none = 1'b0, rb, fw, dw;
      int n;
      if (op == 8'h00) begin c = 4'd0; ok = 1'b1; none = 1'b1; end
      else if (op == 8'hFF) begin c = 4'd14; ok = 1'b1; none = 1'b1; end
      else if (op inside {[1:6], [11:13]}) begin
         c = op[3:0];
         ok = 1'b1;
         case (md)
            8'h00: begin dk = 2'd1; sk = 2'd1; end
            8'h01: begin dk = 2'd1; sk = 2'd2; end
            8'h02: begin dk = 2'd2; sk = 2'd1; end
            8'h03: begin dk = 2'd1; sk = 2'd3; end
            8'h05: begin dk = 2'd2; sk = 2'd2; end
            8'h06: begin dk = 2'd2; sk = 2'd3; end
            default: ok = 1'b0;
         endcase
      end else if (op == 8'h07) begin
         c = 4'd7;
         if (md == 8'h00) begin dk = 2'd1; ok = 1'b1; end
         if (md == 8'h01) begin dk = 2'd2; ok = 1'b1; end
      end else if (op inside {[8:10]}) begin
         c = op[3:0];
         if (md == 8'h00) begin sk = 2'd1; ok = 1'b1; end
         if (md == 8'h01) begin sk = 2'd2; ok = 1'b1; end
         if (md == 8'h03) begin sk = 2'd3; ok = 1'b1; end
      end
      if (!ok) return {4'd15, 2'd0, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1};
      if (none) return {c, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0};
      rb = (dk == 2'd1) || (sk == 2'd1);
      n  = ((dk >= 2'd2) ? 1 : 0) + ((sk >= 2'd2) ? 1 : 0);
      fw = c inside {[2:7], [11:13]};
      dw = c inside {[1:7], 11, 12};
      return {c, dk, sk, (n != 0), rb, 3'(2 + (rb ? 1 : 0) + n), fw, dw, 1'b0};
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s op=%h mode=%h actual=%h expected=%h", tag, in_opcode, in_mode, act, exp);
      end
   endtask

   // Offer one header at a falling edge; its fields are checked at the next falling edge
   task automatic offer(string tag, logic [7:0] op, logic [7:0] md, logic [15:0] exp);
      in_valid = 1'b1; in_opcode = op; in_mode = md;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, {15'd0, out_valid}, 16'd1);
      check(tag, observed(), exp);
   endtask

   task automatic t_reset();
      check("R1", {15'd0, out_valid}, 16'd0);
      check("R1", observed(), 16'd0);
   endtask

   task automatic t_pair_modes();
      foreach (pair_ops[i]) begin
         for (int m = 0; m < 18; m++) begin
            logic [7:0] md = (m < 16) ? 8'(m) : ((m == 16) ? 8'h40 : 8'hFF);
            offer((md inside {0, 1, 2, 3, 5, 6}) ? "R4" : "R5", pair_ops[i], md,
                  expect_of(pair_ops[i], md));
         end
      end
   endtask
   logic [7:0] pair_ops [9] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h0C, 8'h0D};

   task automatic t_single_operand();
      for (int op = 7; op <= 10; op++)
         for (int m = 0; m < 9; m++)
            offer("R8", 8'(op), (m == 8) ? 8'h81 : 8'(m), expect_of(8'(op), (m == 8) ? 8'h81 : 8'(m)));
   endtask

   task automatic t_no_mode();
      offer("R7", 8'h00, 8'h00, {4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 3'b000});
      offer("R7", 8'h00, 8'h04, {4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 3'b000});
      offer("R7", 8'hFF, 8'h5A, {4'd14, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 3'b000});
      offer("R7", 8'hFF, 8'hFF, {4'd14, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 3'b000});
   endtask

   task automatic t_undefined();
      for (int op = 14; op < 255; op++) begin
         offer("R6", 8'(op), 8'h00, expect_of(8'(op), 8'h00));
         offer("R6", 8'(op), 8'h03, expect_of(8'(op), 8'h03));
      end
   endtask

   task automatic t_spot();
      offer("R3", 8'h0C, 8'h03, {4'd12, 2'd1, 2'd3, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0});
      offer("R9", 8'h02, 8'h05, {4'd2, 2'd2, 2'd2, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0});
      offer("R10", 8'h06, 8'h00, {4'd6, 2'd1, 2'd1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0});
      offer("R11", 8'h01, 8'h03, {4'd1, 2'd1, 2'd3, 1'b1, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0});
      offer("R11", 8'h0D, 8'h00, {4'd13, 2'd1, 2'd1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0});
      offer("R11", 8'h09, 8'h03, {4'd9, 2'd0, 2'd3, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0});
      offer("R12", 8'h04, 8'h04, {4'd15, 2'd0, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1});
   endtask

   task automatic t_hold();
      logic [15:0] kept;
      offer("R2", 8'h03, 8'h02, expect_of(8'h03, 8'h02));
      kept = observed();
      in_valid = 1'b0; in_opcode = 8'hEE; in_mode = 8'h07;
      @(negedge clk);
      check("R2", {15'd0, out_valid}, 16'd0);
      check("R2", observed(), kept);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_spot();
      t_no_mode();
      t_pair_modes();
      t_single_operand();
      t_undefined();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule